// File: doc/BRIEF.md
# Addressless I2C Sensor Slave

This block is the serial front end of a light-sensor core. It listens on a synchronized I2C clock and data pair and answers to one of eight 7-bit addresses. The high nibble of the address is fixed at `1000`. Three strap pins supply the low three bits.

The slave has no register pointer. Every written data byte replaces a single command byte and pulses a strobe toward the core. A read streams a fixed sequence of bytes: the 16-bit result and then the 16-bit cycle count, each with the low byte first. When the core runs on its own internal timing, only the two result bytes are offered.

A command whose top bit is set, other than the sleep code `0x8C`, turns on a loopback test. While loopback is on, every byte read returns the stored command. The read bytes are frozen into a shadow copy at the moment the read address is accepted.

Top module: `snsr_i2c_slave`

## Requirements
- R1: The slave acknowledges only the address {1000, strap[2:0]}. It pulls SDA low in the ninth clock of the address byte. Any other address gets no acknowledge.
- R2: After a matching write address, each data byte is acknowledged. The byte becomes `cmd_byte`, and `cmd_strobe` pulses.
- R3: A write that carries only the address ends at the stop condition. It pulses `cmd_strobe` once and leaves `cmd_byte` unchanged.
- R4: With external timing active, a read returns four bytes in this order: result[7:0], result[15:8], count[7:0], count[15:8].
- R5: With external timing inactive, the slave releases SDA after the second read byte. The master then sees 0xFF for any further byte.
- R6: While the stored command has bit 7 set and is not 0x8C, every byte offered by a read equals the stored command.
- R7: The stored command 0x8C is not treated as a loopback test. Reads return core data while it is stored.
- R8: Read bytes are captured when the read address is accepted. A change of the core inputs during the read does not alter the bytes that are returned.
- R9: `sda_pull` changes only while SCL is low.
- R10: A repeated start in the middle of a byte abandons that byte and restarts address reception. A partial byte never changes `cmd_byte`.
- R11: `cmd_strobe` lasts exactly one clock. `cmd_byte` changes only in a strobe cycle.
- R12: After reset, `sda_pull` is 0, `cmd_byte` is 0x00 and `cmd_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| strap_i | input | 3 | Low three address bits |
| result_i | input | 16 | Latest conversion result from the core |
| cycles_i | input | 16 | Cycle count of the latest conversion |
| ext_timing_i | input | 1 | High while an externally timed mode is active |
| sda_pull | output | 1 | Pull SDA low when high |
| cmd_byte | output | 8 | Stored command byte |
| cmd_strobe | output | 1 | One-cycle pulse on each command write or reissue |

## Verification
The core can update its result in the same cycle that a read is streaming result bytes out. The bench provokes this by changing the result input between the low byte and the high byte of a read. It then judges the high byte against the value present when the address was accepted.

A reissue strobe and the start of a new address phase also share a cycle when a repeated start cuts off a write. The bench checks that case through the strobe count, the unchanged command byte, and a correct read in the restarted transfer.

// File: rtl/snsr_i2c_pkg.sv
package snsr_i2c_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          WORD_W     = 16;
    localparam int          RD_BYTES   = 2 * WORD_W / BYTE_W;
    localparam logic [3:0]  DEV_ID_HI  = 4'b1000;
    localparam logic [7:0]  CMD_SLEEP  = 8'h8C;
    localparam logic [7:0]  CMD_INIT   = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_st_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Loopback test: top bit set, but the sleep code keeps its own meaning.
    function automatic logic is_loopback(input logic [BYTE_W-1:0] c);
        return c[BYTE_W-1] && (c != CMD_SLEEP);
    endfunction

endpackage

// File: rtl/snsr_bus_events.sv
module snsr_bus_events
    import snsr_i2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        evt.rise  = scl & ~scl_q;
        evt.fall  = ~scl & scl_q;
        evt.start = scl & scl_q & sda_q & ~sda;
        evt.stop  = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/snsr_cmd_store.sv
module snsr_cmd_store
    import snsr_i2c_pkg::*;
#(
    parameter int            W       = BYTE_W,
    parameter logic [W-1:0]  INIT    = CMD_INIT
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         reissue,
    input  logic [W-1:0] din,
    output logic [W-1:0] cmd,
    output logic         strobe,
    output logic         loopback
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd    <= INIT;
            strobe <= 1'b0;
        end else begin
            strobe <= load | reissue;
            if (load) cmd <= din;
        end
    end

    assign loopback = is_loopback(cmd);
endmodule

// File: rtl/snsr_read_shadow.sv
module snsr_read_shadow
    import snsr_i2c_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NB = 2 * W / BYTE_W,
    localparam int IDX_W = $clog2(NB)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [W-1:0]      result,
    input  logic [W-1:0]      cycles,
    input  logic              ext_timing,
    input  logic              loopback,
    input  logic [BYTE_W-1:0] loop_val,
    input  logic [IDX_W-1:0]  sel,
    output logic [BYTE_W-1:0] byte_o,
    output logic [IDX_W:0]    avail
);
    logic [2*W-1:0]    src;
    logic [BYTE_W-1:0] shd [NB];

    assign src = {cycles, result};

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)          shd[b] <= '0;
            else if (capture) shd[b] <= loopback ? loop_val : src[b*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          avail <= '0;
        else if (capture) avail <= ext_timing ? (IDX_W+1)'(NB) : (IDX_W+1)'(NB/2);
    end

    assign byte_o = shd[sel];
endmodule

// File: rtl/snsr_i2c_slave.sv
module snsr_i2c_slave
    import snsr_i2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [2:0]  strap_i,
    input  logic [15:0] result_i,
    input  logic [15:0] cycles_i,
    input  logic        ext_timing_i,
    output logic        sda_pull,
    output logic [7:0]  cmd_byte,
    output logic        cmd_strobe
);
    localparam int IDX_W = $clog2(RD_BYTES);

    bus_evt_t           evt;
    bus_st_e            st;
    logic [3:0]         bitcnt;
    logic [BYTE_W-1:0]  sr, rd_sh, byte_o;
    logic               rw, wr_empty, nak, loopback;
    logic [IDX_W:0]     idx, next_idx, avail;
    logic [IDX_W-1:0]   sel;
    logic               byte_end, addr_hit, capture, load, reissue;

    snsr_bus_events u_evt (.clk(clk), .rst(rst), .scl(scl_i), .sda(sda_i), .evt(evt));

    snsr_cmd_store #(.W(BYTE_W), .INIT(CMD_INIT)) u_cmd (
        .clk(clk), .rst(rst), .load(load), .reissue(reissue), .din(sr),
        .cmd(cmd_byte), .strobe(cmd_strobe), .loopback(loopback)
    );

    snsr_read_shadow #(.W(WORD_W)) u_shd (
        .clk(clk), .rst(rst), .capture(capture), .result(result_i),
        .cycles(cycles_i), .ext_timing(ext_timing_i), .loopback(loopback),
        .loop_val(cmd_byte), .sel(sel), .byte_o(byte_o), .avail(avail)
    );

    always_comb begin
        byte_end = evt.fall && (bitcnt == 4'd8);
        addr_hit = (sr[7:1] == {DEV_ID_HI, strap_i});
        capture  = (st == ST_ADDR) && byte_end && addr_hit && sr[0];
        load     = (st == ST_WR) && byte_end && !evt.start && !evt.stop;
        reissue  = (evt.start || evt.stop) && wr_empty;
        next_idx = idx + 1'b1;
        sel      = (st == ST_ADDR_ACK) ? '0 : next_idx[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            sr       <= '0;
            rd_sh    <= '0;
            rw       <= 1'b0;
            wr_empty <= 1'b0;
            nak      <= 1'b0;
            idx      <= '0;
            sda_pull <= 1'b0;
        end else if (evt.start) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            wr_empty <= 1'b0;
            sda_pull <= 1'b0;
        end else if (evt.stop) begin
            st       <= ST_IDLE;
            wr_empty <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            unique case (st)
                ST_ADDR, ST_WR: begin
                    if (evt.rise) begin
                        sr     <= {sr[6:0], sda_i};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                        if (st == ST_WR) begin
                            st       <= ST_WR_ACK;
                            sda_pull <= 1'b1;
                            wr_empty <= 1'b0;
                        end else if (addr_hit) begin
                            st       <= ST_ADDR_ACK;
                            sda_pull <= 1'b1;
                            rw       <= sr[0];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: if (evt.fall) begin
                    bitcnt <= '0;
                    idx    <= '0;
                    if (rw) begin
                        st       <= ST_RD;
                        rd_sh    <= byte_o;
                        sda_pull <= ~byte_o[7];
                    end else begin
                        st       <= ST_WR;
                        sda_pull <= 1'b0;
                        wr_empty <= 1'b1;
                    end
                end
                ST_WR_ACK: if (evt.fall) begin
                    st       <= ST_WR;
                    sda_pull <= 1'b0;
                end
                ST_RD: begin
                    if (evt.rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_end) begin
                        st       <= ST_RD_ACK;
                        sda_pull <= 1'b0;
                        bitcnt   <= '0;
                    end else if (evt.fall) begin
                        sda_pull <= ~rd_sh[6];
                        rd_sh    <= {rd_sh[6:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (evt.rise) begin
                        nak <= sda_i;
                    end else if (evt.fall) begin
                        if (!nak && (next_idx < avail)) begin
                            st       <= ST_RD;
                            idx      <= next_idx;
                            rd_sh    <= byte_o;
                            sda_pull <= ~byte_o[7];
                        end else begin
                            st       <= ST_IDLE;
                            sda_pull <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/snsr_i2c_slave_chk.sv
module snsr_i2c_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_pull,
    input logic       cmd_strobe,
    input logic [7:0] cmd_byte
);
    // R9
    a_r9_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> !scl_i);

    // R11
    a_r11_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);

    // R11
    a_r11_cmd_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (cmd_byte != $past(cmd_byte)) |-> cmd_strobe);

    // R5
    a_r5_stop_release: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull);

    // R12
    a_r12_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_pull && !cmd_strobe && cmd_byte == 8'h00));
endmodule

bind snsr_i2c_slave snsr_i2c_slave_chk u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_pull(sda_pull), .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte)
);

// File: tb/snsr_i2c_slave_test.sv
module snsr_i2c_slave_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0]  strap;
    logic [15:0] res, cyc;
    logic        ext;
    logic        sda_pull, cmd_strobe;
    logic [7:0]  cmd_byte;
    wire         sda_line = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    snsr_i2c_slave uut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
        .result_i(res), .cycles_i(cyc), .ext_timing_i(ext),
        .sda_pull(sda_pull), .cmd_byte(cmd_byte), .cmd_strobe(cmd_strobe)
    );

    int checks = 0, fails = 0, strobes = 0, pull_bad = 0, run = 0, max_run = 0;
    bit done = 0;
    logic pull_q = 1'b0, scl_prev = 1'b1;

    always @(posedge clk) begin
        if (!rst) begin
            if (cmd_strobe) begin strobes++; run++; end else run = 0;
            if (run > max_run) max_run = run;
            if ((sda_pull !== pull_q) && scl_prev) pull_bad++;
        end
        pull_q   <= sda_pull;
        scl_prev <= m_scl;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw; repeat (4) @(negedge clk); endtask

    task automatic bstart;
        m_sda = 1'b1; hw; m_scl = 1'b1; hw; m_sda = 1'b0; hw; m_scl = 1'b0; hw;
    endtask

    task automatic bstop;
        m_sda = 1'b0; hw; m_scl = 1'b1; hw; m_sda = 1'b1; hw;
    endtask

    task automatic tx(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hw; m_scl = 1'b1; hw; m_scl = 1'b0;
        end
        m_sda = 1'b1; hw; m_scl = 1'b1; hw; ack = ~sda_line; m_scl = 1'b0;
    endtask

    task automatic rx(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw; m_scl = 1'b1; hw; b[i] = sda_line; m_scl = 1'b0;
        end
        m_sda = nack; hw; m_scl = 1'b1; hw; m_scl = 1'b0; m_sda = 1'b1;
    endtask

    task automatic rd(input logic [6:0] a, input int n, output logic ack, output logic [31:0] d);
        logic [7:0] b;
        d = '1;
        bstart;
        tx({a, 1'b1}, ack);
        if (ack) begin
            for (int k = 0; k < n; k++) begin
                rx(k == n - 1, b);
                d[k*8 +: 8] = b;
            end
        end
        bstop;
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] v, output logic aa, output logic ad);
        bstart;
        tx({a, 1'b0}, aa);
        ad = 1'b0;
        if (aa) tx(v, ad);
        bstop;
    endtask

    typedef struct packed {
        logic [2:0]  strap;
        logic        ext;
        logic [15:0] res;
        logic [15:0] cyc;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{3'd4, 1'b1, 16'h1234, 16'h5678},
        '{3'd0, 1'b0, 16'hBEEF, 16'hCAFE},
        '{3'd7, 1'b1, 16'h00FF, 16'hFF00},
        '{3'd2, 1'b0, 16'h8001, 16'h7FFE}
    };

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary;
            $finish;
        end
    end

    initial begin
        logic        a1, a2;
        logic [31:0] d;
        logic [7:0]  b0, b1;
        int          s0;
        strap = 3'd0; res = '0; cyc = '0; ext = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 pull", {31'd0, sda_pull}, 32'd0);
        chk("R12 cmd", {24'd0, cmd_byte}, 32'h00);
        chk("R12 strobe", {31'd0, cmd_strobe}, 32'd0);

        // Table walk: R1 address match, R4 four-byte order, R5 two-byte limit
        for (int v = 0; v < 4; v++) begin
            strap = VECS[v].strap; ext = VECS[v].ext;
            res = VECS[v].res; cyc = VECS[v].cyc;
            hw;
            rd({4'b1000, VECS[v].strap}, 4, a1, d);
            chk("R1 ack", {31'd0, a1}, 32'd1);
            chk(VECS[v].ext ? "R4 order" : "R5 limit", d,
                VECS[v].ext ? {VECS[v].cyc, VECS[v].res} : {16'hFFFF, VECS[v].res});
        end

        // R1: foreign address is not acknowledged
        strap = 3'd3; ext = 1'b1; res = 16'hA1B2; cyc = 16'hC3D4;
        s0 = strobes;
        rd(7'h45, 2, a1, d);
        chk("R1 foreign", {31'd0, a1}, 32'd0);
        wr(7'h41, 8'h55, a1, a2);
        chk("R1 foreign wr", {31'd0, a1}, 32'd0);
        chk("R1 no strobe", strobes - s0, 32'd0);

        // R2: write replaces command
        s0 = strobes;
        wr(7'h43, 8'h30, a1, a2);
        chk("R2 ack", {30'd0, a1, a2}, 32'd3);
        chk("R2 cmd", {24'd0, cmd_byte}, 32'h30);
        chk("R2 strobe", strobes - s0, 32'd1);

        // R3: address-only write reissues
        s0 = strobes;
        bstart; tx(8'h86, a1); bstop;
        hw;
        chk("R3 ack", {31'd0, a1}, 32'd1);
        chk("R3 strobe", strobes - s0, 32'd1);
        chk("R3 cmd kept", {24'd0, cmd_byte}, 32'h30);

        // R6: loopback test
        wr(7'h43, 8'hA5, a1, a2);
        ext = 1'b0;
        rd(7'h43, 2, a1, d);
        chk("R6 loop2", d, 32'hFFFFA5A5);
        ext = 1'b1;
        rd(7'h43, 4, a1, d);
        chk("R6 loop4", d, 32'hA5A5A5A5);

        // R7: sleep code is not a loopback
        wr(7'h43, 8'h8C, a1, a2);
        chk("R7 cmd", {24'd0, cmd_byte}, 32'h8C);
        rd(7'h43, 4, a1, d);
        chk("R7 data", d, 32'hC3D4A1B2);

        // R8: snapshot across a mid-read update
        ext = 1'b0; res = 16'h3C5A;
        hw;
        bstart; tx(8'h87, a1);
        rx(1'b0, b0);
        res = 16'hFFFF;
        rx(1'b1, b1);
        bstop;
        chk("R8 snapshot", {16'd0, b1, b0}, 32'h00003C5A);

        // R10: repeated start mid-byte
        res = 16'h6E91;
        s0 = strobes;
        bstart; tx(8'h86, a1);
        for (int i = 0; i < 3; i++) begin
            m_sda = 1'b0; hw; m_scl = 1'b1; hw; m_scl = 1'b0;
        end
        bstart;
        tx(8'h87, a1);
        rx(1'b0, b0);
        rx(1'b1, b1);
        bstop;
        hw;
        chk("R10 ack", {31'd0, a1}, 32'd1);
        chk("R10 data", {16'd0, b1, b0}, 32'h00006E91);
        chk("R10 cmd kept", {24'd0, cmd_byte}, 32'h8C);
        chk("R10 reissue", strobes - s0, 32'd1);

        // R11 and R9 from the monitors
        chk("R11 strobe width", max_run, 32'd1);
        chk("R9 pull edges", pull_bad, 32'd0);

        done = 1;
        summary;
        $finish;
    end
endmodule